// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block paces a small processor core from one input clock. It splits the clock into four non-overlapping phases that repeat without gaps. Each group of four phases is one instruction cycle, with the phases named Q1 to Q4. Across these cycles the block runs a two-stage pipeline. While one instruction executes, the next one is fetched. This lets straight-line code complete one instruction per cycle.

The block owns the program counter, a fetch latch and the instruction register. It presents the fetch address to program memory and takes the returned word. It hands the word to an external execute stage, which decodes it and sends back requests for a data read, a data write or a branch. The block turns these requests into data-memory strobes, each at one fixed phase. When a branch is taken, the block redirects fetching. The word that was already fetched behind the branch is marked invalid, so its execute slot does nothing.

Top module: `quad_phase_seq`

## Requirements
- R1: `phase_o` is one-hot, with bit 0 for Q1, bit 1 for Q2, bit 2 for Q3 and bit 3 for Q4. It advances one bit per clock in the order Q1, Q2, Q3, Q4, then back to Q1. Reset puts it at Q1.
- R2: `clk_out` is high during Q1 and Q2 and low during Q3 and Q4. It therefore runs at one quarter of the input clock rate.
- R3: `imem_addr` changes only at the clock edge that ends Q4.
  - If no branch is taken, it steps by 2, so the new value applies from Q1.
  - Reset clears it to 0.
- R4: The word on `imem_rdata` is captured at the end of Q4. At the end of the following Q1 it moves into `ex_ir`, with its fetch address on `ex_pc`. It then stays there through Q2, Q3 and Q4. Execution therefore trails fetch by exactly one instruction cycle.
- R5: `dmem_rd` is high only in Q2, and only when `ex_ir_valid` and `ex_rd_req` are both high.
- R6: `dmem_wr` is high only in Q4, and only when `ex_ir_valid` and `ex_wr_req` are both high.
- R7: A branch is taken when `ex_branch` is high with `ex_ir_valid` high at the edge ending Q4.
  - The next fetch address is then `ex_target`.
  - The word fetched behind the branch occupies the next execute slot with `ex_ir_valid` low.
  - Any read, write or branch request in that slot has no effect.
- R8: A branch request made while `ex_ir_valid` is low does not change the fetch sequence.
- R9: After the invalid slot, the instruction at the branch target executes in the very next cycle, with no further bubble.
- R10: After reset, `ex_ir` holds the NOP encoding (all zeros by default) and `ex_ir_valid` is low. As a result, the first execute slot after reset performs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one phase per period |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Program memory fetch address (program counter) |
| imem_rdata | input | INSTR_W | Instruction word returned for `imem_addr` |
| ex_ir | output | INSTR_W | Instruction register contents for the execute stage |
| ex_ir_valid | output | 1 | Instruction register holds a live instruction |
| ex_pc | output | PC_W | Fetch address of the word in `ex_ir` |
| ex_rd_req | input | 1 | Execute stage wants an operand read |
| ex_wr_req | input | 1 | Execute stage wants a result write |
| ex_branch | input | 1 | Execute stage requests a control transfer |
| ex_target | input | PC_W | Branch target address |
| dmem_rd | output | 1 | Data-memory read strobe (Q2) |
| dmem_wr | output | 1 | Data-memory write strobe (Q4) |
| phase_o | output | 4 | One-hot current phase |
| clk_out | output | 1 | Instruction-cycle rate clock output |

## Verification
The assertions assume three things about the inputs:
- Program memory returns the word for `imem_addr` combinationally and in time for the edge that ends Q4.
- The execute stage derives its requests from `ex_ir` alone.
- The execute stage holds `ex_target` steady through Q4.

The bench stays within these limits. Its execute stub decodes `ex_ir` without looking at `ex_ir_valid`, and its program memory is a plain array indexed by the address. As a result, a flushed store or flushed branch really does raise a request, and the design is seen to ignore it.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PH_Q1 = 0;
  localparam int PH_Q2 = 1;
  localparam int PH_Q3 = 2;
  localparam int PH_Q4 = 3;
endpackage

// File: rtl/qps_phase_gen.sv
module qps_phase_gen #(
  parameter int NPH = qps_pkg::NUM_PHASES
) (
  input  logic           clk,
  input  logic           rst,
  output logic [NPH-1:0] ph_oh,
  output logic           clk_out
);
  localparam int HALF = NPH / 2;

  logic [NPH-1:0] ph_nxt;

  always_comb begin
    ph_nxt = {ph_oh[NPH-2:0], ph_oh[NPH-1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_oh   <= NPH'(1);
      clk_out <= 1'b1;
    end else begin
      ph_oh   <= ph_nxt;
      clk_out <= |ph_nxt[HALF-1:0];
    end
  end
endmodule

// File: rtl/qps_fetch.sv
module qps_fetch #(
  parameter int              PC_W     = 12,
  parameter int              INSTR_W  = 16,
  parameter int              PC_STEP  = 2,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_end,
  input  logic               br_take,
  input  logic [PC_W-1:0]    br_target,
  input  logic [INSTR_W-1:0] rdata,
  output logic [PC_W-1:0]    pc,
  output logic [INSTR_W-1:0] flatch,
  output logic [PC_W-1:0]    flatch_pc,
  output logic               flatch_ok
);
  logic [PC_W-1:0] pc_seq;

  always_comb begin
    pc_seq = pc + PC_W'(PC_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= RESET_PC;
      flatch    <= NOP_WORD;
      flatch_pc <= RESET_PC;
      flatch_ok <= 1'b0;
    end else if (cyc_end) begin
      flatch    <= rdata;
      flatch_pc <= pc;
      flatch_ok <= ~br_take;
      pc        <= br_take ? br_target : pc_seq;
    end
  end
endmodule

// File: rtl/qps_exec.sv
module qps_exec #(
  parameter int                 PC_W     = 12,
  parameter int                 INSTR_W  = 16,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic               rd_phase,
  input  logic               wr_phase,
  input  logic               end_phase,
  input  logic [INSTR_W-1:0] flatch,
  input  logic [PC_W-1:0]    flatch_pc,
  input  logic               flatch_ok,
  input  logic               rd_req,
  input  logic               wr_req,
  input  logic               br_req,
  output logic [INSTR_W-1:0] ir,
  output logic               ir_ok,
  output logic [PC_W-1:0]    ir_pc,
  output logic               br_take,
  output logic               rd_stb,
  output logic               wr_stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ir    <= NOP_WORD;
      ir_ok <= 1'b0;
      ir_pc <= '0;
    end else if (load_en) begin
      ir    <= flatch;
      ir_ok <= flatch_ok;
      ir_pc <= flatch_pc;
    end
  end

  always_comb begin
    br_take = end_phase & ir_ok & br_req;
    rd_stb  = rd_phase  & ir_ok & rd_req;
    wr_stb  = wr_phase  & ir_ok & wr_req;
  end
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq #(
  parameter int                 PC_W     = 12,
  parameter int                 INSTR_W  = 16,
  parameter int                 PC_STEP  = 2,
  parameter logic [PC_W-1:0]    RESET_PC = '0,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [INSTR_W-1:0] ex_ir,
  output logic               ex_ir_valid,
  output logic [PC_W-1:0]    ex_pc,
  input  logic               ex_rd_req,
  input  logic               ex_wr_req,
  input  logic               ex_branch,
  input  logic [PC_W-1:0]    ex_target,
  output logic               dmem_rd,
  output logic               dmem_wr,
  output logic [qps_pkg::NUM_PHASES-1:0] phase_o,
  output logic               clk_out
);
  import qps_pkg::*;

  logic [NUM_PHASES-1:0] ph;
  logic [INSTR_W-1:0]    flatch;
  logic [PC_W-1:0]       flatch_pc;
  logic                  flatch_ok;
  logic                  br_take;

  qps_phase_gen #(.NPH(NUM_PHASES)) u_phase (
    .clk(clk), .rst(rst), .ph_oh(ph), .clk_out(clk_out)
  );

  qps_fetch #(
    .PC_W(PC_W), .INSTR_W(INSTR_W), .PC_STEP(PC_STEP),
    .RESET_PC(RESET_PC), .NOP_WORD(NOP_WORD)
  ) u_fetch (
    .clk(clk), .rst(rst), .cyc_end(ph[PH_Q4]),
    .br_take(br_take), .br_target(ex_target), .rdata(imem_rdata),
    .pc(imem_addr), .flatch(flatch), .flatch_pc(flatch_pc),
    .flatch_ok(flatch_ok)
  );

  qps_exec #(
    .PC_W(PC_W), .INSTR_W(INSTR_W), .NOP_WORD(NOP_WORD)
  ) u_exec (
    .clk(clk), .rst(rst), .load_en(ph[PH_Q1]),
    .rd_phase(ph[PH_Q2]), .wr_phase(ph[PH_Q4]), .end_phase(ph[PH_Q4]),
    .flatch(flatch), .flatch_pc(flatch_pc), .flatch_ok(flatch_ok),
    .rd_req(ex_rd_req), .wr_req(ex_wr_req), .br_req(ex_branch),
    .ir(ex_ir), .ir_ok(ex_ir_valid), .ir_pc(ex_pc),
    .br_take(br_take), .rd_stb(dmem_rd), .wr_stb(dmem_wr)
  );

  assign phase_o = ph;
endmodule

// File: rtl/qps_checker.sv
module qps_checker #(
  parameter int PC_W    = 12,
  parameter int INSTR_W = 16,
  parameter int PC_STEP = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [PC_W-1:0]    imem_addr,
  input logic [INSTR_W-1:0] ex_ir,
  input logic               ex_ir_valid,
  input logic               ex_branch,
  input logic [PC_W-1:0]    ex_target,
  input logic               dmem_rd,
  input logic               dmem_wr,
  input logic [3:0]         phase_o,
  input logic               clk_out
);
  a_r1_phase_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(phase_o));
  a_r1_phase_rotate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_o == {$past(phase_o[2:0]), $past(phase_o[3])});
  a_r2_clkout_level: assert property (@(posedge clk) disable iff (rst)
    clk_out == (phase_o[0] | phase_o[1]));
  a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !phase_o[3] |=> $stable(imem_addr));
  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    (phase_o[3] && !(ex_ir_valid && ex_branch)) |=>
      imem_addr == $past(imem_addr) + PC_W'(PC_STEP));
  a_r4_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !phase_o[0] |=> $stable(ex_ir));
  a_r5_rd_phase: assert property (@(posedge clk) disable iff (rst)
    dmem_rd |-> (phase_o[1] && ex_ir_valid));
  a_r6_wr_phase: assert property (@(posedge clk) disable iff (rst)
    dmem_wr |-> (phase_o[3] && ex_ir_valid));
  a_r7_target: assert property (@(posedge clk) disable iff (rst)
    (phase_o[3] && ex_ir_valid && ex_branch) |=> imem_addr == $past(ex_target));
  a_r7_flush_slot: assert property (@(posedge clk) disable iff (rst)
    (phase_o[3] && ex_ir_valid && ex_branch) |-> ##2 !ex_ir_valid);
endmodule

bind quad_phase_seq qps_checker #(
  .PC_W(PC_W), .INSTR_W(INSTR_W), .PC_STEP(PC_STEP)
) u_qps_checker (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .ex_ir(ex_ir),
  .ex_ir_valid(ex_ir_valid), .ex_branch(ex_branch), .ex_target(ex_target),
  .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .phase_o(phase_o), .clk_out(clk_out)
);

// File: tb/quad_phase_seq_test.sv
module quad_phase_seq_test;
  localparam int PC_W = 12;
  localparam int IW   = 16;
  localparam int NCYC = 24;
  localparam logic [3:0] OP_NOP = 4'h0, OP_LIT = 4'h1, OP_ST = 4'h2,
                         OP_BR = 4'h3, OP_RD = 4'h4;

  typedef struct {
    logic [PC_W-1:0] fa;
    logic [PC_W-1:0] ea;
    logic            ev;
    logic            rd;
    logic            wr;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] imem_addr, ex_pc, ex_target;
  logic [IW-1:0]   imem_rdata, ex_ir;
  logic ex_ir_valid, ex_rd_req, ex_wr_req, ex_branch, dmem_rd, dmem_wr, clk_out;
  logic [3:0] phase_o;
  logic [IW-1:0] mem [64];
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_phase_seq uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .ex_ir(ex_ir), .ex_ir_valid(ex_ir_valid), .ex_pc(ex_pc),
    .ex_rd_req(ex_rd_req), .ex_wr_req(ex_wr_req), .ex_branch(ex_branch),
    .ex_target(ex_target), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .phase_o(phase_o), .clk_out(clk_out)
  );

  // program memory and an execute stub that decodes ex_ir without gating
  assign imem_rdata = mem[imem_addr[6:1]];
  assign ex_wr_req  = ex_ir[15:12] == OP_ST;
  assign ex_rd_req  = ex_ir[15:12] == OP_RD;
  assign ex_branch  = ex_ir[15:12] == OP_BR;
  assign ex_target  = ex_ir[11:0];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: walks the program from the requirements and queues expectations
  task automatic build_expect();
    logic [PC_W-1:0] f = '0, pa = '0;
    logic pv = 1'b0;
    for (int c = 0; c < NCYC; c++) begin
      exp_t e;
      logic [IW-1:0] w = mem[pa[6:1]];
      logic take;
      e.fa = f; e.ea = pa; e.ev = pv;
      e.rd = pv && w[15:12] == OP_RD;
      e.wr = pv && w[15:12] == OP_ST;
      take = pv && w[15:12] == OP_BR;
      q.push_back(e);
      pa = f;
      pv = !take;
      f  = take ? w[11:0] : f + 12'd2;
    end
  endtask

  // monitor: one pass per phase, sampled at the falling edge
  task automatic monitor();
    exp_t cur;
    for (int c = 0; c < NCYC; c++) begin
      for (int p = 0; p < 4; p++) begin
        chk(phase_o == 4'(1 << p), "R1", phase_o, 1 << p);
        chk(clk_out == (p < 2), "R2", clk_out, p < 2);
        if (p == 1) begin
          cur = q.pop_front();
          chk(imem_addr == cur.fa, "R3/R7/R8 fetch", imem_addr, cur.fa);
          chk(ex_ir_valid == cur.ev, "R7/R9/R10 valid", ex_ir_valid, cur.ev);
          if (cur.ev) begin
            chk(ex_pc == cur.ea, "R4/R9 exec pc", ex_pc, cur.ea);
            chk(ex_ir == mem[cur.ea[6:1]], "R4 ir word", ex_ir, mem[cur.ea[6:1]]);
          end
          chk(dmem_rd == cur.rd, "R5 rd", dmem_rd, cur.rd);
        end else begin
          chk(dmem_rd == 1'b0, "R5 rd off-phase", dmem_rd, 0);
        end
        if (p == 3) chk(dmem_wr == cur.wr, "R6/R7 wr", dmem_wr, cur.wr);
        else        chk(dmem_wr == 1'b0, "R6 wr off-phase", dmem_wr, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = {OP_NOP, 12'h000};
    mem[8'h00 >> 1] = {OP_LIT, 12'h055};
    mem[8'h02 >> 1] = {OP_ST,  12'h000};
    mem[8'h04 >> 1] = {OP_BR,  12'h010};
    mem[8'h06 >> 1] = {OP_ST,  12'h000}; // flushed store
    mem[8'h10 >> 1] = {OP_ST,  12'h000};
    mem[8'h12 >> 1] = {OP_BR,  12'h020};
    mem[8'h14 >> 1] = {OP_BR,  12'h030}; // flushed branch, R8
    mem[8'h20 >> 1] = {OP_RD,  12'h000};
    mem[8'h22 >> 1] = {OP_BR,  12'h022}; // branch to itself
    mem[8'h30 >> 1] = {OP_ST,  12'h000};
    build_expect();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 0, "R3 reset pc", imem_addr, 0);
    chk(phase_o == 4'b0001, "R1 reset phase", phase_o, 1);
    chk(ex_ir_valid == 0, "R10 reset valid", ex_ir_valid, 0);
    chk(ex_ir == 0, "R10 reset ir", ex_ir, 0);
    chk(clk_out == 1, "R2 reset clk_out", clk_out, 1);
    rst = 1'b0;
    monitor();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule